// File: doc/BRIEF.md
# Four-Terminal Concentrator with Local Crossbar

This block lets four terminal nodes share one injection port and one ejection port of a network router. Flits from the terminals are examined for their destination: a flit addressed to another group is queued for the single router-facing output, with a round-robin arbiter choosing among terminals. A flit addressed to a terminal of the same group never reaches the router; it travels over a private four-by-four crossbar straight to the destination terminal. On the return side, flits arriving from the router are steered to one of the four terminal outputs by their terminal field.

Every channel uses a valid/ready handshake. A packet is a run of flits ending in a flit with the tail bit set, and every arbitration decision is held from the packet's first flit to its tail. Each terminal output is shared between the ejection stream and the local crossbar. When both start a packet toward the same idle output in one cycle, the ejection stream is granted first.

Top module: `conc_local_bypass`

## Requirements
- R1: After reset, with no input valid, `injValid`, every `termOutValid` bit, every `termInReady` bit and `ejReady` are 0.
- R2: A flit is global when its group field (the top GRP_W bits) differs from `groupId`. Global flits leave unchanged on `injFlit`, and `injFlit` never carries a flit whose group equals `groupId`.
- R3: A flit whose group field equals `groupId` is delivered unchanged to the terminal output named by its terminal field (the TERM_W bits just above the tail bit), and never to the router.
- R4: A flit from the router is delivered unchanged to the terminal output named by its terminal field.
- R5: Router injection is granted round-robin. After reset terminal 0 has first priority. After a tail flit is sent, the terminal one above the winner (modulo 4) has first priority.
- R6: At every output, the flits of one packet appear back to back. An output accepts at most one source per cycle, and a grant lasts from a packet's first flit to its tail flit (bit PAY_W).
- R7: Local packets that compete for one terminal output are granted round-robin per output. Each output has its own pointer, which starts at terminal 0 and moves one above the last winner after that winner's tail.
- R8: When an ejected packet and a local packet both start toward the same idle terminal output in one cycle, the ejected packet goes first. A local packet that already owns the output keeps it until its tail.
- R9: Local transfers to different terminal outputs proceed in the same cycle.
- R10: Under any pattern of backpressure, no flit is lost or duplicated, and the flits from one source to one sink arrive in the order they were sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| groupId | input | GRP_W | Group number of this concentrator |
| termInValid | input | 4 | Flit offered by each terminal |
| termInReady | output | 4 | Terminal flit accepted this cycle |
| termInFlit | input | 4 x FLIT_W | Flit from each terminal |
| injValid | output | 1 | Flit offered to the router |
| injReady | input | 1 | Router accepts the injected flit |
| injFlit | output | FLIT_W | Flit toward the router |
| ejValid | input | 1 | Flit offered by the router |
| ejReady | output | 1 | Ejected flit accepted this cycle |
| ejFlit | input | FLIT_W | Flit from the router |
| termOutValid | output | 4 | Flit offered to each terminal |
| termOutReady | input | 4 | Terminal accepts the flit |
| termOutFlit | output | 4 x FLIT_W | Flit toward each terminal |

## Verification
The collision that matters is an ejected packet and a local packet that both reach the same terminal output in one cycle. The bench provokes it by loading a two-flit ejection packet and a two-flit local packet toward terminal 2 before the first cycle after reset. It then checks that the sink sees both ejected flits before either local one, and that nothing reaches the router. In a mixed run with random backpressure the same collision recurs many times while other outputs are locked. There a per-sink scoreboard judges contiguity, ordering and routing flit by flit.

// File: rtl/conc_pkg.sv
package conc_pkg;
  localparam int N_TERM = 4;
  localparam int TERM_W = $clog2(N_TERM);

  typedef logic [TERM_W-1:0] termIdx_t;

  // strobes from control to datapath
  typedef struct packed {
    termIdx_t                injSrc;
    logic [N_TERM-1:0]       outFromEj;
    termIdx_t [N_TERM-1:0]   outSrc;
  } strobe_t;

  function automatic termIdx_t rrPick(input logic [N_TERM-1:0] req, input termIdx_t ptr);
    termIdx_t pick;
    termIdx_t cand;
    logic found;
    pick  = ptr;
    found = 1'b0;
    for (int k = 0; k < N_TERM; k++) begin
      cand = termIdx_t'((int'(ptr) + k) % N_TERM);
      if (!found && req[cand]) begin
        pick  = cand;
        found = 1'b1;
      end
    end
    return pick;
  endfunction
endpackage

// File: rtl/conc_ctrl.sv
module conc_ctrl
  import conc_pkg::*;
#(
  parameter int GRP_W = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [GRP_W-1:0]              groupId,
  input  logic [N_TERM-1:0]             inValid,
  input  logic [N_TERM-1:0][GRP_W-1:0]  inGrp,
  input  termIdx_t [N_TERM-1:0]         inTerm,
  input  logic [N_TERM-1:0]             inLast,
  output logic [N_TERM-1:0]             inReady,
  output logic                          injValid,
  input  logic                          injReady,
  input  logic                          ejValid,
  input  termIdx_t                      ejTerm,
  input  logic                          ejLast,
  output logic                          ejReady,
  output logic [N_TERM-1:0]             outValid,
  input  logic [N_TERM-1:0]             outReady,
  output strobe_t                       strb
);
  logic [N_TERM-1:0] isLocal, gReq;
  logic injLock;
  termIdx_t injOwner, injPtr, injSel;
  logic injFire;

  logic [N_TERM-1:0][N_TERM-1:0] locReq;
  logic [N_TERM-1:0] ejWants, useEj, outFire;
  logic [N_TERM-1:0] ejLock, locLock;
  termIdx_t [N_TERM-1:0] locOwner, locPtr, locSel;

  always_comb begin
    for (int i = 0; i < N_TERM; i++) begin
      isLocal[i] = (inGrp[i] == groupId);
      gReq[i]    = inValid[i] && !isLocal[i];
    end
    injSel   = injLock ? injOwner : rrPick(gReq, injPtr);
    injValid = gReq[injSel];
    injFire  = injValid && injReady;
  end

  always_comb begin
    for (int j = 0; j < N_TERM; j++) begin
      for (int i = 0; i < N_TERM; i++)
        locReq[j][i] = inValid[i] && isLocal[i] && (inTerm[i] == termIdx_t'(j));
      ejWants[j]  = ejValid && (ejTerm == termIdx_t'(j));
      useEj[j]    = ejLock[j] || (!locLock[j] && ejWants[j]);
      locSel[j]   = locLock[j] ? locOwner[j] : rrPick(locReq[j], locPtr[j]);
      outValid[j] = useEj[j] ? ejWants[j] : locReq[j][locSel[j]];
      outFire[j]  = outValid[j] && outReady[j];
    end
    ejReady = ejValid && useEj[ejTerm] && outReady[ejTerm];
    for (int i = 0; i < N_TERM; i++) begin
      if (isLocal[i])
        inReady[i] = inValid[i] && !useEj[inTerm[i]] &&
                     (locSel[inTerm[i]] == termIdx_t'(i)) && outReady[inTerm[i]];
      else
        inReady[i] = gReq[i] && (injSel == termIdx_t'(i)) && injReady;
    end
  end

  always_comb begin
    strb.injSrc    = injSel;
    strb.outFromEj = useEj;
    strb.outSrc    = locSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      injLock  <= 1'b0;
      injOwner <= '0;
      injPtr   <= '0;
      ejLock   <= '0;
      locLock  <= '0;
      locOwner <= '0;
      locPtr   <= '0;
    end else begin
      if (injFire) begin
        injLock  <= !inLast[injSel];
        injOwner <= injSel;
        if (inLast[injSel]) injPtr <= termIdx_t'(injSel + 1'b1);
      end
      for (int j = 0; j < N_TERM; j++) begin
        if (outFire[j]) begin
          if (useEj[j]) begin
            ejLock[j] <= !ejLast;
          end else begin
            locLock[j]  <= !inLast[locSel[j]];
            locOwner[j] <= locSel[j];
            if (inLast[locSel[j]]) locPtr[j] <= termIdx_t'(locSel[j] + 1'b1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/conc_dpath.sv
module conc_dpath
  import conc_pkg::*;
#(
  parameter int FLIT_W = 23
) (
  input  logic [N_TERM-1:0][FLIT_W-1:0] termInFlit,
  input  logic [FLIT_W-1:0]             ejFlit,
  input  strobe_t                       strb,
  output logic [FLIT_W-1:0]             injFlit,
  output logic [N_TERM-1:0][FLIT_W-1:0] termOutFlit
);
  assign injFlit = termInFlit[strb.injSrc];

  for (genvar j = 0; j < N_TERM; j++) begin : g_out
    assign termOutFlit[j] = strb.outFromEj[j] ? ejFlit : termInFlit[strb.outSrc[j]];
  end
endmodule

// File: rtl/conc_local_bypass.sv
module conc_local_bypass
  import conc_pkg::*;
#(
  parameter int GRP_W = 4,
  parameter int PAY_W = 16,
  localparam int FLIT_W = GRP_W + TERM_W + 1 + PAY_W
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [GRP_W-1:0]              groupId,
  input  logic [N_TERM-1:0]             termInValid,
  output logic [N_TERM-1:0]             termInReady,
  input  logic [N_TERM-1:0][FLIT_W-1:0] termInFlit,
  output logic                          injValid,
  input  logic                          injReady,
  output logic [FLIT_W-1:0]             injFlit,
  input  logic                          ejValid,
  output logic                          ejReady,
  input  logic [FLIT_W-1:0]             ejFlit,
  output logic [N_TERM-1:0]             termOutValid,
  input  logic [N_TERM-1:0]             termOutReady,
  output logic [N_TERM-1:0][FLIT_W-1:0] termOutFlit
);
  localparam int LAST_BIT = PAY_W;
  localparam int TERM_LSB = PAY_W + 1;

  logic [N_TERM-1:0][GRP_W-1:0] inGrp;
  termIdx_t [N_TERM-1:0] inTerm;
  logic [N_TERM-1:0] inLast;
  strobe_t strb;

  always_comb begin
    for (int i = 0; i < N_TERM; i++) begin
      inGrp[i]  = termInFlit[i][FLIT_W-1 -: GRP_W];
      inTerm[i] = termInFlit[i][TERM_LSB +: TERM_W];
      inLast[i] = termInFlit[i][LAST_BIT];
    end
  end

  conc_ctrl #(.GRP_W(GRP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .groupId(groupId),
    .inValid(termInValid), .inGrp(inGrp), .inTerm(inTerm), .inLast(inLast),
    .inReady(termInReady), .injValid(injValid), .injReady(injReady),
    .ejValid(ejValid), .ejTerm(ejFlit[TERM_LSB +: TERM_W]), .ejLast(ejFlit[LAST_BIT]),
    .ejReady(ejReady), .outValid(termOutValid), .outReady(termOutReady), .strb(strb)
  );

  conc_dpath #(.FLIT_W(FLIT_W)) u_dpath (
    .termInFlit(termInFlit), .ejFlit(ejFlit), .strb(strb),
    .injFlit(injFlit), .termOutFlit(termOutFlit)
  );
endmodule

// File: rtl/conc_local_bypass_chk.sv
module conc_local_bypass_chk
  import conc_pkg::*;
#(
  parameter int GRP_W = 4,
  parameter int PAY_W = 16,
  localparam int FLIT_W = GRP_W + TERM_W + 1 + PAY_W
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [GRP_W-1:0]              groupId,
  input logic [N_TERM-1:0]             termInValid,
  input logic [N_TERM-1:0]             termInReady,
  input logic [N_TERM-1:0][FLIT_W-1:0] termInFlit,
  input logic                          injValid,
  input logic                          injReady,
  input logic [FLIT_W-1:0]             injFlit,
  input logic                          ejValid,
  input logic                          ejReady,
  input logic [FLIT_W-1:0]             ejFlit,
  input logic [N_TERM-1:0]             termOutValid,
  input logic [N_TERM-1:0]             termOutReady,
  input logic [N_TERM-1:0][FLIT_W-1:0] termOutFlit
);
  localparam int TERM_LSB = PAY_W + 1;

  logic [N_TERM-1:0] globAcc;
  logic [N_TERM-1:0][N_TERM-1:0] locAccTo;
  termIdx_t ejDst;

  always_comb begin
    ejDst = ejFlit[TERM_LSB +: TERM_W];
    for (int i = 0; i < N_TERM; i++)
      globAcc[i] = termInValid[i] && termInReady[i] &&
                   (termInFlit[i][FLIT_W-1 -: GRP_W] != groupId);
    for (int j = 0; j < N_TERM; j++)
      for (int i = 0; i < N_TERM; i++)
        locAccTo[j][i] = termInValid[i] && termInReady[i] &&
                         (termInFlit[i][FLIT_W-1 -: GRP_W] == groupId) &&
                         (termInFlit[i][TERM_LSB +: TERM_W] == termIdx_t'(j));
  end

  // R2: router output never carries an in-group flit
  a_r2_far_only: assert property (@(posedge clk) disable iff (!rstN)
    injValid |-> (injFlit[FLIT_W-1 -: GRP_W] != groupId));

  // R2: one terminal feeds the router per accepted flit
  a_r2_one_grant: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(globAcc) && ((injValid && injReady) == (|globAcc)));

  // R4, R10: an accepted ejected flit is delivered in the same cycle
  a_r4_ej_forward: assert property (@(posedge clk) disable iff (!rstN)
    (ejValid && ejReady) |-> (termOutValid[ejDst] && termOutReady[ejDst] &&
                              termOutFlit[ejDst] == ejFlit));

  for (genvar j = 0; j < N_TERM; j++) begin : g_out
    // R3, R4: output carries flits for its own terminal only
    a_r4_term_match: assert property (@(posedge clk) disable iff (!rstN)
      termOutValid[j] |-> (termOutFlit[j][TERM_LSB +: TERM_W] == termIdx_t'(j)));
    // R6: at most one writer per output per cycle
    a_r6_single_writer: assert property (@(posedge clk) disable iff (!rstN)
      $countones({locAccTo[j], (ejValid && ejReady && ejDst == termIdx_t'(j))}) <= 1);
    for (genvar i = 0; i < N_TERM; i++) begin : g_src
      // R3: accepted local flit reaches its output unchanged
      a_r3_local_copy: assert property (@(posedge clk) disable iff (!rstN)
        locAccTo[j][i] |-> (termOutValid[j] && termOutReady[j] &&
                            termOutFlit[j] == termInFlit[i]));
    end
  end

  for (genvar i = 0; i < N_TERM; i++) begin : g_inj
    // R2: accepted global flit leaves unchanged
    a_r2_inj_copy: assert property (@(posedge clk) disable iff (!rstN)
      globAcc[i] |-> (injFlit == termInFlit[i]));
  end
endmodule

bind conc_local_bypass conc_local_bypass_chk #(.GRP_W(GRP_W), .PAY_W(PAY_W)) u_chk (
  .clk(clk), .rstN(rstN), .groupId(groupId),
  .termInValid(termInValid), .termInReady(termInReady), .termInFlit(termInFlit),
  .injValid(injValid), .injReady(injReady), .injFlit(injFlit),
  .ejValid(ejValid), .ejReady(ejReady), .ejFlit(ejFlit),
  .termOutValid(termOutValid), .termOutReady(termOutReady), .termOutFlit(termOutFlit)
);

// File: tb/conc_local_bypass_tb.sv
module conc_local_bypass_tb;
  import conc_pkg::*;
  localparam int GRP_W = 4;
  localparam int PAY_W = 16;
  localparam int FLIT_W = GRP_W + TERM_W + 1 + PAY_W;
  localparam logic [GRP_W-1:0] MY_GRP  = 4'h5;
  localparam logic [GRP_W-1:0] FAR_GRP = 4'hA;
  localparam int NS = 5;   // 0..3 terminals, 4 = router side
  localparam int QD = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N_TERM-1:0] termInValid, termInReady, termOutValid, termOutReady;
  logic [N_TERM-1:0][FLIT_W-1:0] termInFlit, termOutFlit;
  logic injValid, injReady, ejValid, ejReady;
  logic [FLIT_W-1:0] injFlit, ejFlit;

  conc_local_bypass #(.GRP_W(GRP_W), .PAY_W(PAY_W)) u_dut (
    .clk(clk), .rstN(rstN), .groupId(MY_GRP),
    .termInValid(termInValid), .termInReady(termInReady), .termInFlit(termInFlit),
    .injValid(injValid), .injReady(injReady), .injFlit(injFlit),
    .ejValid(ejValid), .ejReady(ejReady), .ejFlit(ejFlit),
    .termOutValid(termOutValid), .termOutReady(termOutReady), .termOutFlit(termOutFlit)
  );

  always #10 clk = ~clk;   // 50 MHz

  int vectors = 0, miscompares = 0;
  logic [FLIT_W-1:0] q[NS][QD];
  int qLen[NS], qPtr[NS];
  int txSeq[NS][NS], rxSeq[NS][NS];
  int logSrc[NS][QD], logCyc[NS][QD], logN[NS];
  bit curOpen[NS];
  int curSrc[NS];
  bit stress;
  logic [15:0] lfsr = 16'hACE1;
  int cyc = 0;

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clearAll();
    for (int s = 0; s < NS; s++) begin
      qLen[s] = 0; qPtr[s] = 0; logN[s] = 0; curOpen[s] = 0; curSrc[s] = 0;
      for (int k = 0; k < NS; k++) begin txSeq[s][k] = 0; rxSeq[s][k] = 0; end
    end
  endtask

  task automatic driveIdle();
    termInValid = '0; termInFlit = '0; ejValid = 1'b0; ejFlit = '0;
    termOutReady = '1; injReady = 1'b1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    driveIdle();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    clearAll();
  endtask

  // src 4 = router; glob selects router as the sink
  task automatic addPkt(int src, bit glob, int dst, int len);
    int sink;
    sink = glob ? 4 : dst;
    for (int f = 0; f < len; f++) begin
      q[src][qLen[src]] = {(glob ? FAR_GRP : MY_GRP), 2'(dst), (f == len - 1),
                           4'(src), 12'(txSeq[src][sink])};
      txSeq[src][sink]++;
      qLen[src]++;
    end
  endtask

  task automatic driveCycle();
    for (int s = 0; s < N_TERM; s++) begin
      termInValid[s] = (qPtr[s] < qLen[s]);
      termInFlit[s]  = termInValid[s] ? q[s][qPtr[s]] : '0;
    end
    ejValid = (qPtr[4] < qLen[4]);
    ejFlit  = ejValid ? q[4][qPtr[4]] : '0;
    if (stress) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      termOutReady = lfsr[3:0] | lfsr[7:4];
      injReady = lfsr[8] | lfsr[11];
    end else begin
      termOutReady = '1; injReady = 1'b1;
    end
  endtask

  task automatic sampleSink(int k, logic [FLIT_W-1:0] f);
    int src, seq;
    bit routeOk;
    src = int'(f[15:12]);
    seq = int'(f[11:0]);
    if (k < N_TERM) begin
      routeOk = (f[PAY_W+1 +: TERM_W] == 2'(k)) && (src == 4 || f[FLIT_W-1 -: GRP_W] == MY_GRP);
      check(src == 4 ? "R4 ejection steer" : "R3 local delivery", int'(routeOk), 1);
    end else begin
      check("R2 global only to router", int'(f[FLIT_W-1 -: GRP_W] != MY_GRP), 1);
    end
    check("R10 order per source", seq, rxSeq[src % NS][k]);
    rxSeq[src % NS][k]++;
    if (curOpen[k]) check("R6 packet contiguity", src, curSrc[k]);
    curOpen[k] = !f[PAY_W];
    curSrc[k] = src;
    logSrc[k][logN[k]] = src;
    logCyc[k][logN[k]] = cyc;
    logN[k]++;
  endtask

  task automatic runPhase(int maxCyc);
    int n;
    bit done;
    n = 0;
    forever begin
      @(negedge clk);
      done = 1;
      for (int s = 0; s < NS; s++) if (qPtr[s] < qLen[s]) done = 0;
      if (done) break;
      driveCycle();
      #5;
      for (int s = 0; s < N_TERM; s++) if (termInValid[s] && termInReady[s]) qPtr[s]++;
      if (ejValid && ejReady) qPtr[4]++;
      for (int k = 0; k < N_TERM; k++)
        if (termOutValid[k] && termOutReady[k]) sampleSink(k, termOutFlit[k]);
      if (injValid && injReady) sampleSink(4, injFlit);
      cyc++;
      n++;
      if (n > maxCyc) begin
        check("watchdog R10 drain", n, maxCyc);
        break;
      end
    end
    driveIdle();
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < NS; k++)
        if (txSeq[s][k] != 0) check("R10 no loss or duplicate", rxSeq[s][k], txSeq[s][k]);
  endtask

  initial begin
    driveIdle();
    stress = 0;
    clearAll();

    // R1: idle after reset
    doReset();
    #5;
    check("R1 injValid idle", int'(injValid), 0);
    check("R1 termOutValid idle", int'(termOutValid), 0);
    check("R1 termInReady idle", int'(termInReady), 0);
    check("R1 ejReady idle", int'(ejReady), 0);

    // R5: router round-robin from terminal 0
    doReset();
    for (int r = 0; r < 2; r++)
      for (int s = 0; s < N_TERM; s++) addPkt(s, 1, 3, 1);
    runPhase(100);
    check("R5 grant count", logN[4], 8);
    for (int g = 0; g < 8; g++) check("R5 grant order", logSrc[4][g], g % N_TERM);

    // R7: per-output round-robin toward terminal 2
    doReset();
    for (int r = 0; r < 2; r++) begin
      addPkt(0, 0, 2, 1); addPkt(1, 0, 2, 1); addPkt(3, 0, 2, 1);
    end
    runPhase(100);
    check("R7 grant count", logN[2], 6);
    for (int g = 0; g < 6; g++) check("R7 grant order", logSrc[2][g], (g % 3 == 2) ? 3 : g % 3);

    // R8: ejection beats a local packet at an idle output
    doReset();
    addPkt(4, 0, 2, 2);
    addPkt(0, 0, 2, 2);
    runPhase(100);
    check("R8 flit count", logN[2], 4);
    check("R8 first", logSrc[2][0], 4);
    check("R8 second", logSrc[2][1], 4);
    check("R8 third", logSrc[2][2], 0);
    check("R8 fourth", logSrc[2][3], 0);
    check("R3 nothing to router", logN[4], 0);

    // R9: four disjoint local transfers in one cycle
    doReset();
    addPkt(0, 0, 1, 1); addPkt(1, 0, 0, 1); addPkt(2, 0, 3, 1); addPkt(3, 0, 2, 1);
    runPhase(100);
    for (int k = 0; k < N_TERM; k++) begin
      check("R9 one flit per output", logN[k], 1);
      check("R9 same cycle", logCyc[k][0], logCyc[0][0]);
    end
    check("R9 nothing to router", logN[4], 0);

    // R2, R3, R4, R6, R10: mixed traffic under backpressure
    doReset();
    stress = 1;
    for (int s = 0; s < N_TERM; s++)
      for (int k = 0; k < 30; k++) begin
        int sel;
        sel = (s * 7 + k * 3) % 6;
        addPkt(s, sel >= 4, (sel >= 4) ? k % 4 : sel, 1 + (k + s) % 3);
      end
    for (int k = 0; k < 30; k++) addPkt(4, 0, (k * 3 + 1) % 4, 1 + k % 2);
    runPhase(5000);
    stress = 0;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule